// File: doc/BRIEF.md
# DMA Channel Command and Status Register Block

This block is the software-visible front of one DMA channel. A processor reaches it through a simple 32-bit bus with a write strobe, a write address and write data, plus a read address and combinational read data. It does not move data. It turns register writes into one-cycle command strobes and level requests for a transfer engine. It holds the channel configuration. It collects event pulses from the engine into sticky flags and raises one interrupt line.

Three word addresses are decoded; an address is valid only when its two low bits are zero and every bit above the word index is zero. Word 0 is the command word. It is write-only and reads as zero. Each 1 written to it fires a command or clears a flag. Word 1 is the control word. Each interrupt enable in it has its own set bit and clear bit, so one write can change a single enable without a read-modify-write. Word 2 is the status word. It is read-only. Its sticky flags are cleared only through command bits in word 0, never by writing the status word back.

Top module: `dcr_chan_regs`

## Requirements
- R1: After reset every enable, flag, configuration output, link-pause and send-terminal-count level, strobe and `irq` is 0, and the control and status words read as 0 while the engine inputs are idle.
- R2: A write to word 0 pulses `cmd_start`, `cmd_cont`, `cmd_stop`, `cmd_abort`, `cmd_fifo_rst` and `cmd_chan_rst` for exactly the one cycle after the write edge, for data bits 0, 1, 2, 3, 4 and 31 respectively. Word 0 reads as 0.
- R3: Enable k (k=7 global, 6 link pause, 5 SAR, 4 done, 3 memory-ready, 2 device-ready, 1 link-complete, 0 ring/continue) is set by control bit 17+2k and cleared by control bit 16+2k. If both bits are 1, or both are 0, the enable keeps its value. The enable reads back at bit 17+2k, and bit 16+2k reads 0.
- R4: Control bit 15 (FIFO disable), 14 (burst), 6 (device-side swap), 4 (memory-side swap), 3 (device-to-memory) and 2..0 (mode: 0 normal, 1 continue, 2 ring, 4 short chain, 5 long chain) are loaded by each control write. They drive the `cfg_*` outputs and read back in place. The other bits read 0.
- R5: A 1 on `ev_set[k]` at a clock edge sets sticky flag k (same index order as R3, k=0..6). The flag appears at status bit 17+2k and stays set after the input drops.
- R6: In word 0, bit 7 clears the done flag (k=4), bit 5 the link-complete flag (k=1) and bit 6 the ring/continue flag (k=0). When an event for the same flag arrives in the same cycle as its clear, the flag stays set.
- R7: `irq` and status bit 31 equal the global enable ANDed with the OR over k of (flag k AND enable k).
- R8: In word 0, bit 9 sets and bit 8 clears `link_pause`, and bit 11 sets and bit 10 clears `send_tc`. When both bits of a pair are 1, the level keeps its value.
- R9: Word 0 bit 31 clears all enables, flags, configuration fields, `link_pause` and `send_tc` at that edge. This takes precedence over events and over the other bits of that write.
- R10: Status bits 14, 13, 12 and 9 show `eng_soft_abort`, `eng_hard_abort`, `eng_stopped` and `eng_xfer_err`. Bits 5..4, 3..2 and 1..0 show the link, memory and device error codes (1 bus, 2 retry, 3 other). Bit 15 is 1 when the transfer error is set or any code is nonzero.
- R11: A write to word 2, to an unmapped address, or with `wr_en` low changes no state and fires no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | ADDR_W | Byte write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | ADDR_W | Byte read address |
| rd_data | output | 32 | Combinational read data |
| ev_set | input | 7 | Event pulses from the engine, one per sticky flag |
| eng_stopped | input | 1 | Engine stopped |
| eng_soft_abort | input | 1 | Engine ended by software abort |
| eng_hard_abort | input | 1 | Engine ended by hardware abort |
| eng_xfer_err | input | 1 | Transfer error |
| eng_link_err | input | 2 | Link fetch error code |
| eng_mem_err | input | 2 | Memory side error code |
| eng_dev_err | input | 2 | Device side error code |
| cmd_start | output | 1 | Start strobe |
| cmd_cont | output | 1 | Continue strobe |
| cmd_stop | output | 1 | Stop-after-drain strobe |
| cmd_abort | output | 1 | Abort-without-drain strobe |
| cmd_fifo_rst | output | 1 | FIFO reset strobe |
| cmd_chan_rst | output | 1 | Channel reset strobe |
| link_pause | output | 1 | Link pause request level |
| send_tc | output | 1 | Send terminal count level |
| cfg_fifo_dis | output | 1 | FIFO disabled |
| cfg_burst | output | 1 | Bursts enabled |
| cfg_swap_dev | output | 1 | Device-side byte swap |
| cfg_swap_mem | output | 1 | Memory-side byte swap |
| cfg_dev2mem | output | 1 | Direction, 1 = device to memory |
| cfg_mode | output | 3 | Transfer mode code |
| irq | output | 1 | Channel interrupt |

## Verification
The hardest situations to reach are the collisions inside one edge. These are an event pulse arriving in the same cycle as the command that clears that flag, and a channel reset written while events are arriving. Random stimulus seldom lines these up. The bench therefore forces each collision directly, then runs a long random mix: dense event pulses, command words with sparse reset bits, and control words where both bits of an enable pair are often set together. After every edge a bench-side model predicts each output and both readable words.

// File: rtl/dcr_pkg.sv
// Package: shared constants and types for the DMA channel register block.
// Assumes a 32-bit data bus and the fixed bit layout given in the brief.
package dcr_pkg;
    localparam int DATA_W = 32;
    localparam int NUM_EV = 7;            // sticky event flags
    localparam int NUM_IE = NUM_EV + 1;   // plus the global enable
    localparam int PAIR_LSB = 16;         // lowest clear bit of enable pairs
    localparam int MODE_W = 3;

    typedef enum logic [1:0] {
        W_OP   = 2'd0,
        W_CTRL = 2'd1,
        W_STAT = 2'd2,
        W_NONE = 2'd3
    } word_e;

    // Flag indices with a command-word clear.
    localparam int F_RING = 0;
    localparam int F_LINK = 1;
    localparam int F_DONE = 4;

    typedef struct packed {
        logic              fifo_dis;
        logic              burst;
        logic              swap_dev;
        logic              swap_mem;
        logic              dev2mem;
        logic [MODE_W-1:0] mode;
    } cfg_t;
endpackage

// File: rtl/dcr_enable_pairs.sv
// Module: interrupt enables written through set/clear bit pairs.
// Assumes set and clear vectors come from one control-word write; a channel
// reset clears everything and wins over the write.
module dcr_enable_pairs
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_stb,
    input  logic              chan_rst,
    input  logic [NUM_IE-1:0] set_vec,
    input  logic [NUM_IE-1:0] clr_vec,
    output logic [NUM_IE-1:0] ie_q
);
    for (genvar k = 0; k < NUM_IE; k++) begin : g_pair
        // Purpose: update one enable; equal set/clear keeps the value.
        always_ff @(posedge clk) begin
            if (!rst_n || chan_rst) begin
                ie_q[k] <= 1'b0;
            end else if (wr_stb && (set_vec[k] != clr_vec[k])) begin
                ie_q[k] <= set_vec[k];
            end
        end
    end
endmodule

// File: rtl/dcr_event_flags.sv
// Module: sticky event flags set by engine pulses.
// Assumes clear requests are one-cycle; an event in the same cycle as its
// clear keeps the flag set, and a channel reset clears all flags.
module dcr_event_flags
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              chan_rst,
    input  logic [NUM_EV-1:0] ev_set,
    input  logic [NUM_EV-1:0] clr_vec,
    output logic [NUM_EV-1:0] fl_q
);
    for (genvar k = 0; k < NUM_EV; k++) begin : g_flag
        // Purpose: hold one flag until cleared; setting beats clearing.
        always_ff @(posedge clk) begin
            if (!rst_n || chan_rst) begin
                fl_q[k] <= 1'b0;
            end else if (ev_set[k]) begin
                fl_q[k] <= 1'b1;
            end else if (clr_vec[k]) begin
                fl_q[k] <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dcr_cmd_decode.sv
// Module: decodes command-word writes into strobes, flag clears and the
// link-pause / send-terminal-count levels.
// Assumes op_stb is high for exactly the cycle of a command-word write.
module dcr_cmd_decode
    import dcr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              op_stb,
    input  logic [11:0]       op_lo,
    input  logic              op_rst,
    output logic              chan_rst,
    output logic [NUM_EV-1:0] clr_vec,
    output logic              cmd_start,
    output logic              cmd_cont,
    output logic              cmd_stop,
    output logic              cmd_abort,
    output logic              cmd_fifo_rst,
    output logic              cmd_chan_rst,
    output logic              link_pause,
    output logic              send_tc
);
    // Purpose: channel reset request seen in the write cycle.
    assign chan_rst = op_stb && op_rst;

    // Purpose: map clear bits onto flag indices.
    always_comb begin
        clr_vec         = '0;
        clr_vec[F_DONE] = op_stb && op_lo[7];
        clr_vec[F_RING] = op_stb && op_lo[6];
        clr_vec[F_LINK] = op_stb && op_lo[5];
    end

    // Purpose: register one-cycle command strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_start    <= 1'b0;
            cmd_cont     <= 1'b0;
            cmd_stop     <= 1'b0;
            cmd_abort    <= 1'b0;
            cmd_fifo_rst <= 1'b0;
            cmd_chan_rst <= 1'b0;
        end else begin
            cmd_start    <= op_stb && op_lo[0];
            cmd_cont     <= op_stb && op_lo[1];
            cmd_stop     <= op_stb && op_lo[2];
            cmd_abort    <= op_stb && op_lo[3];
            cmd_fifo_rst <= op_stb && op_lo[4];
            cmd_chan_rst <= chan_rst;
        end
    end

    // Purpose: paired set/clear levels; equal bits keep the value.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            link_pause <= 1'b0;
            send_tc    <= 1'b0;
        end else if (op_stb) begin
            if (op_lo[9] != op_lo[8])   link_pause <= op_lo[9];
            if (op_lo[11] != op_lo[10]) send_tc    <= op_lo[11];
        end
    end
endmodule

// File: rtl/dcr_chan_regs.sv
// Module: top of the per-channel command/status register block.
// Assumes aligned 32-bit accesses; ADDR_W >= 4 byte address bits, with
// bits above the word index required to be zero for a hit.
module dcr_chan_regs
    import dcr_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [31:0]       wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [31:0]       rd_data,
    input  logic [6:0]        ev_set,
    input  logic              eng_stopped,
    input  logic              eng_soft_abort,
    input  logic              eng_hard_abort,
    input  logic              eng_xfer_err,
    input  logic [1:0]        eng_link_err,
    input  logic [1:0]        eng_mem_err,
    input  logic [1:0]        eng_dev_err,
    output logic              cmd_start,
    output logic              cmd_cont,
    output logic              cmd_stop,
    output logic              cmd_abort,
    output logic              cmd_fifo_rst,
    output logic              cmd_chan_rst,
    output logic              link_pause,
    output logic              send_tc,
    output logic              cfg_fifo_dis,
    output logic              cfg_burst,
    output logic              cfg_swap_dev,
    output logic              cfg_swap_mem,
    output logic              cfg_dev2mem,
    output logic [2:0]        cfg_mode,
    output logic              irq
);
    localparam int HI_W = ADDR_W - 4;

    logic              wr_hit;
    word_e             wr_word;
    logic              op_stb;
    logic              ctrl_stb;
    logic              chan_rst;
    logic [NUM_EV-1:0] clr_vec;
    logic [NUM_IE-1:0] set_vec;
    logic [NUM_IE-1:0] pclr_vec;
    logic [NUM_IE-1:0] ie_q;
    logic [NUM_EV-1:0] fl_q;
    cfg_t              cfg_q;
    logic [31:0]       ctrl_word;
    logic [31:0]       stat_word;

    // Purpose: decode a write hit; upper and low byte bits must be zero.
    always_comb begin
        wr_hit  = wr_en && (wr_addr[1:0] == 2'b00);
        wr_word = word_e'(wr_addr[3:2]);
        if (HI_W > 0) begin
            wr_hit = wr_hit && ((wr_addr >> 4) == '0);
        end
    end
    assign op_stb   = wr_hit && (wr_word == W_OP);
    assign ctrl_stb = wr_hit && (wr_word == W_CTRL);

    // Purpose: split enable pairs into set and clear vectors.
    for (genvar k = 0; k < NUM_IE; k++) begin : g_split
        assign set_vec[k]  = wr_data[PAIR_LSB + 2*k + 1];
        assign pclr_vec[k] = wr_data[PAIR_LSB + 2*k];
    end

    dcr_cmd_decode u_cmd (
        .clk          (clk),
        .rst_n        (rst_n),
        .op_stb       (op_stb),
        .op_lo        (wr_data[11:0]),
        .op_rst       (wr_data[31]),
        .chan_rst     (chan_rst),
        .clr_vec      (clr_vec),
        .cmd_start    (cmd_start),
        .cmd_cont     (cmd_cont),
        .cmd_stop     (cmd_stop),
        .cmd_abort    (cmd_abort),
        .cmd_fifo_rst (cmd_fifo_rst),
        .cmd_chan_rst (cmd_chan_rst),
        .link_pause   (link_pause),
        .send_tc      (send_tc)
    );

    dcr_enable_pairs u_ie (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_stb   (ctrl_stb),
        .chan_rst (chan_rst),
        .set_vec  (set_vec),
        .clr_vec  (pclr_vec),
        .ie_q     (ie_q)
    );

    dcr_event_flags u_fl (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_rst (chan_rst),
        .ev_set   (ev_set),
        .clr_vec  (clr_vec),
        .fl_q     (fl_q)
    );

    // Purpose: configuration fields loaded by control writes.
    always_ff @(posedge clk) begin
        if (!rst_n || chan_rst) begin
            cfg_q <= '0;
        end else if (ctrl_stb) begin
            cfg_q.fifo_dis <= wr_data[15];
            cfg_q.burst    <= wr_data[14];
            cfg_q.swap_dev <= wr_data[6];
            cfg_q.swap_mem <= wr_data[4];
            cfg_q.dev2mem  <= wr_data[3];
            cfg_q.mode     <= wr_data[2:0];
        end
    end

    assign cfg_fifo_dis = cfg_q.fifo_dis;
    assign cfg_burst    = cfg_q.burst;
    assign cfg_swap_dev = cfg_q.swap_dev;
    assign cfg_swap_mem = cfg_q.swap_mem;
    assign cfg_dev2mem  = cfg_q.dev2mem;
    assign cfg_mode     = cfg_q.mode;

    // Purpose: interrupt from enabled flags, gated by the global enable.
    assign irq = ie_q[NUM_IE-1] && |(fl_q & ie_q[NUM_EV-1:0]);

    // Purpose: assemble the control and status read words.
    always_comb begin
        ctrl_word     = '0;
        stat_word     = '0;
        for (int k = 0; k < NUM_IE; k++) begin
            ctrl_word[PAIR_LSB + 2*k + 1] = ie_q[k];
        end
        for (int k = 0; k < NUM_EV; k++) begin
            stat_word[PAIR_LSB + 2*k + 1] = fl_q[k];
        end
        ctrl_word[15]  = cfg_q.fifo_dis;
        ctrl_word[14]  = cfg_q.burst;
        ctrl_word[6]   = cfg_q.swap_dev;
        ctrl_word[4]   = cfg_q.swap_mem;
        ctrl_word[3]   = cfg_q.dev2mem;
        ctrl_word[2:0] = cfg_q.mode;
        stat_word[31]  = irq;
        stat_word[15]  = eng_xfer_err || (eng_link_err != 2'b00)
                         || (eng_mem_err != 2'b00) || (eng_dev_err != 2'b00);
        stat_word[14]  = eng_soft_abort;
        stat_word[13]  = eng_hard_abort;
        stat_word[12]  = eng_stopped;
        stat_word[9]   = eng_xfer_err;
        stat_word[5:4] = eng_link_err;
        stat_word[3:2] = eng_mem_err;
        stat_word[1:0] = eng_dev_err;
    end

    // Purpose: read mux; word 0 and unmapped addresses read zero.
    always_comb begin
        rd_data = '0;
        if ((rd_addr[1:0] == 2'b00) && ((rd_addr >> 4) == '0)) begin
            case (word_e'(rd_addr[3:2]))
                W_CTRL:  rd_data = ctrl_word;
                W_STAT:  rd_data = stat_word;
                default: rd_data = '0;
            endcase
        end
    end
endmodule

// File: rtl/dcr_chan_regs_chk.sv
// Module: property checker for dcr_chan_regs, attached by bind below.
// Assumes it observes the top's ports plus its enable and flag vectors.
module dcr_chan_regs_chk #(
    parameter int ADDR_W = 4
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] wr_addr,
    input logic [31:0]       wr_data,
    input logic [7:0]        ie_q,
    input logic [6:0]        fl_q,
    input logic              irq,
    input logic              cmd_start,
    input logic              cmd_chan_rst,
    input logic [2:0]        cfg_mode,
    input logic              link_pause
);
    logic op_wr;
    logic ctrl_wr;
    assign op_wr   = wr_en && (wr_addr == '0);
    assign ctrl_wr = wr_en && (wr_addr == ADDR_W'(4));

    AST_START_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && wr_data[0]) |=> cmd_start);                               // R2
    AST_NO_STRAY_START: assert property (@(posedge clk) disable iff (!rst_n)
        !(op_wr && wr_data[0]) |=> !cmd_start);                             // R11
    AST_PAIR_BOTH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr && wr_data[31] && wr_data[30]) |=> $stable(ie_q[7]));      // R3
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (|($past(fl_q) & ~fl_q)) |-> $past(op_wr));                         // R5
    AST_IRQ_GLOBAL: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (ie_q[7] && |fl_q));                                        // R7
    AST_CHAN_RST_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (op_wr && wr_data[31]) |=> (ie_q == '0 && fl_q == '0 && cfg_mode == '0
                                    && !link_pause && cmd_chan_rst));       // R9
endmodule

bind dcr_chan_regs dcr_chan_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .wr_en        (wr_en),
    .wr_addr      (wr_addr),
    .wr_data      (wr_data),
    .ie_q         (ie_q),
    .fl_q         (fl_q),
    .irq          (irq),
    .cmd_start    (cmd_start),
    .cmd_chan_rst (cmd_chan_rst),
    .cfg_mode     (cfg_mode),
    .link_pause   (link_pause)
);

// File: tb/test_dcr_chan_regs.sv
module test_dcr_chan_regs;
    localparam int ADDR_W = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [31:0] rd_data;
    logic [6:0] ev_set = '0;
    logic eng_stopped = 1'b0, eng_soft_abort = 1'b0, eng_hard_abort = 1'b0;
    logic eng_xfer_err = 1'b0;
    logic [1:0] eng_link_err = '0, eng_mem_err = '0, eng_dev_err = '0;
    logic cmd_start, cmd_cont, cmd_stop, cmd_abort, cmd_fifo_rst, cmd_chan_rst;
    logic link_pause, send_tc;
    logic cfg_fifo_dis, cfg_burst, cfg_swap_dev, cfg_swap_mem, cfg_dev2mem;
    logic [2:0] cfg_mode;
    logic irq;

    int checks = 0;
    int failures = 0;

    // bench model
    logic [7:0]  m_ie = '0;
    logic [6:0]  m_fl = '0;
    logic [7:0]  m_cfg = '0;   // {fifo_dis,burst,swap_dev,swap_mem,dev2mem,mode}
    logic        m_pause = 1'b0, m_tc = 1'b0;
    logic [5:0]  m_strb = '0;  // {chan_rst,fifo_rst,abort,stop,cont,start}

    always #10 clk = ~clk;

    dcr_chan_regs #(.ADDR_W(ADDR_W)) i_dcr_chan_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data),
        .ev_set(ev_set), .eng_stopped(eng_stopped),
        .eng_soft_abort(eng_soft_abort), .eng_hard_abort(eng_hard_abort),
        .eng_xfer_err(eng_xfer_err), .eng_link_err(eng_link_err),
        .eng_mem_err(eng_mem_err), .eng_dev_err(eng_dev_err),
        .cmd_start(cmd_start), .cmd_cont(cmd_cont), .cmd_stop(cmd_stop),
        .cmd_abort(cmd_abort), .cmd_fifo_rst(cmd_fifo_rst),
        .cmd_chan_rst(cmd_chan_rst), .link_pause(link_pause),
        .send_tc(send_tc), .cfg_fifo_dis(cfg_fifo_dis), .cfg_burst(cfg_burst),
        .cfg_swap_dev(cfg_swap_dev), .cfg_swap_mem(cfg_swap_mem),
        .cfg_dev2mem(cfg_dev2mem), .cfg_mode(cfg_mode), .irq(irq)
    );

    task automatic check(input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_ctrl();
        logic [31:0] w = '0;
        for (int k = 0; k < 8; k++) w[17 + 2*k] = m_ie[k];
        w[15] = m_cfg[7]; w[14] = m_cfg[6]; w[6] = m_cfg[5];
        w[4] = m_cfg[4]; w[3] = m_cfg[3]; w[2:0] = m_cfg[2:0];
        return w;
    endfunction

    function automatic logic exp_irq();
        return m_ie[7] && |(m_fl & m_ie[6:0]);
    endfunction

    function automatic logic [31:0] exp_stat();
        logic [31:0] w = '0;
        for (int k = 0; k < 7; k++) w[17 + 2*k] = m_fl[k];
        w[31] = exp_irq();
        w[15] = eng_xfer_err || (eng_link_err != 0) || (eng_mem_err != 0)
                || (eng_dev_err != 0);
        w[14] = eng_soft_abort; w[13] = eng_hard_abort; w[12] = eng_stopped;
        w[9] = eng_xfer_err; w[5:4] = eng_link_err; w[3:2] = eng_mem_err;
        w[1:0] = eng_dev_err;
        return w;
    endfunction

    // Model of one edge, from the requirements.
    task automatic model_edge(input logic we, input logic [3:0] a,
                              input logic [31:0] d, input logic [6:0] ev);
        logic op = we && (a == 4'h0);
        logic ct = we && (a == 4'h4);
        m_strb = op ? {d[31], d[4:0]} : 6'b0;                        // R2 R11
        if (op && d[31]) begin                                       // R9
            m_ie = '0; m_fl = '0; m_cfg = '0; m_pause = 0; m_tc = 0;
            return;
        end
        if (op) begin
            if (d[7]) m_fl[4] = 1'b0;                                // R6
            if (d[5]) m_fl[1] = 1'b0;
            if (d[6]) m_fl[0] = 1'b0;
            if (d[9] != d[8])   m_pause = d[9];                      // R8
            if (d[11] != d[10]) m_tc = d[11];
        end
        m_fl = m_fl | ev;                                            // R5
        if (ct) begin
            for (int k = 0; k < 8; k++)                              // R3
                if (d[17+2*k] != d[16+2*k]) m_ie[k] = d[17+2*k];
            m_cfg = {d[15], d[14], d[6], d[4], d[3], d[2:0]};        // R4
        end
    endtask

    task automatic compare_all(input string tag);
        rd_addr = 4'h4; #1;
        check({tag, " R3 R4 ctrl word"}, rd_data, exp_ctrl());
        rd_addr = 4'h8; #1;
        check({tag, " R5 R7 R10 status word"}, rd_data, exp_stat());
        rd_addr = 4'h0; #1;
        check({tag, " R2 op reads zero"}, rd_data, 32'h0);
        check({tag, " R7 irq"}, {31'b0, irq}, {31'b0, exp_irq()});
        check({tag, " R2 strobes"},
              {26'b0, cmd_chan_rst, cmd_fifo_rst, cmd_abort, cmd_stop,
               cmd_cont, cmd_start}, {26'b0, m_strb});
        check({tag, " R8 levels"}, {30'b0, link_pause, send_tc},
              {30'b0, m_pause, m_tc});
        check({tag, " R4 cfg outputs"},
              {24'b0, cfg_fifo_dis, cfg_burst, cfg_swap_dev, cfg_swap_mem,
               cfg_dev2mem, cfg_mode}, {24'b0, m_cfg});
    endtask

    task automatic cycle(input string tag, input logic we, input logic [3:0] a,
                         input logic [31:0] d, input logic [6:0] ev);
        @(negedge clk);
        wr_en = we; wr_addr = a; wr_data = d; ev_set = ev;
        @(posedge clk);
        #2;
        model_edge(we, a, d, ev);
        wr_en = 1'b0; ev_set = '0;
        compare_all(tag);
    endtask

    initial begin
        #(20 * 200000);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        repeat (3) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        #3;
        m_strb = '0;
        compare_all("R1 reset");

        // Directed corner cases
        cycle("R3 set global+done", 1, 4'h4, 32'h8200_0000, 7'h00);
        cycle("R3 both bits hold", 1, 4'h4, 32'hC300_0000, 7'h00);
        cycle("R5 done event", 0, 4'h0, 0, 7'b001_0000);
        cycle("R7 irq after event", 0, 4'h0, 0, 7'h00);
        cycle("R6 clear vs event same cycle", 1, 4'h0, 32'h80, 7'b001_0000);
        cycle("R6 clear done", 1, 4'h0, 32'h80, 7'h00);
        cycle("R8 pause set", 1, 4'h0, 32'h0000_0A00, 7'h00);
        cycle("R8 both bits hold", 1, 4'h0, 32'h0000_0F00, 7'h00);
        cycle("R4 fields", 1, 4'h4, 32'h0000_C05D, 7'h00);
        cycle("R11 status write", 1, 4'h8, 32'hFFFF_FFFF, 7'h00);
        cycle("R11 wr_en low", 0, 4'h4, 32'h5555_5555, 7'h00);
        cycle("R11 unmapped", 1, 4'h2, 32'hFFFF_FFFF, 7'h00);
        cycle("R9 reset with event", 1, 4'h0, 32'h8000_001F, 7'h7F);
        eng_xfer_err = 1; eng_link_err = 2; eng_stopped = 1;
        cycle("R10 error codes", 0, 4'h0, 0, 7'h00);
        eng_xfer_err = 0; eng_link_err = 0; eng_stopped = 0; eng_dev_err = 3;
        cycle("R10 code only", 0, 4'h0, 0, 7'h00);

        // Constrained random mix
        for (int i = 0; i < 600; i++) begin
            logic [31:0] d = $urandom;
            logic [3:0]  a;
            logic        we = ($urandom % 4) != 0;
            logic [6:0]  ev = ($urandom % 3 == 0) ? 7'($urandom) : 7'h0;
            case ($urandom % 4)
                0, 1: a = 4'h0;
                2:    a = 4'h4;
                default: a = 4'h8;
            endcase
            if (a == 4'h0 && ($urandom % 16) != 0) d[31] = 1'b0;
            if (a == 4'h4 && ($urandom % 2) == 0) d[31:16] = d[31:16] | 16'hAAAA;
            eng_soft_abort = 1'($urandom); eng_hard_abort = 1'($urandom);
            eng_stopped = 1'($urandom); eng_xfer_err = 1'($urandom);
            eng_link_err = 2'($urandom); eng_mem_err = 2'($urandom);
            eng_dev_err = 2'($urandom);
            cycle("random R2 R3 R5 R6 R7 R9 R10", we, a, d, ev);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule